// File: doc/BRIEF.md
# TLB Refill Page-Table Walker

This block services a translation miss without software help. When the lookup logic reports that a virtual address has no matching TLB entry, the walker takes the missing address, the side that missed (instruction or data), the privilege level of the access and the miss cause. It also takes the page-table base register. From these it forms the virtual address of the page-table entry (PTE) that maps the missing page. It sends that address back through the TLB as a privilege-0 data load, reads the 32-bit PTE from memory, and writes a new entry into one of four refill ways. It then reports success, or failure together with the original miss cause.

The PTE address is virtual, so a walk can itself miss. In that case the walker gives up and reports the original miss. A privilege-0 miss whose address lies inside the 4 MiB page-table window is never refilled, because that would be a refill of the page table through itself. Refill ways are used in turn. A two-bit counter is advanced before each write, and the advanced value selects the way. After a successful refill the requester repeats the original access, and the usual ring and permission checks are made on the new entry.

The control is one state machine with six states:
- `S_IDLE`: accepts a miss.
- `S_XLATE`: holds a translate request until it is acknowledged.
- `S_MEM_REQ`: issues a one-cycle read.
- `S_MEM_WAIT`: waits for the read acknowledge.
- `S_WRITE`: writes the TLB entry for one cycle.
- `S_DONE`: reports the result for one cycle.

The transitions are:
- IDLE→XLATE when a miss is accepted.
- IDLE→DONE when the miss is suppressed.
- XLATE→MEM_REQ on an acknowledged hit.
- XLATE→DONE on an acknowledged miss.
- MEM_REQ→MEM_WAIT always.
- MEM_WAIT→WRITE on acknowledge.
- WRITE→DONE always.
- DONE→IDLE always.

Top module: `tlb_refill_walker`

## Requirements
- R1: After reset the walker is idle. `busy`, `xl_req`, `mem_req`, `wr_en` and `done` are all 0, and the way counter is 0, so the first refill goes to way 1.
- R2: The translate address `xl_vaddr` is (`pt_base` OR (`miss_vaddr` >> 10)) with bits [1:0] forced to 0.
- R3: A miss with `miss_priv` = 0 is not walked if `miss_vaddr[31:22]` equals `pt_base[31:22]`. The walker goes straight to `done` with `done_ok` = 0 and `done_cause` = `miss_cause`, and raises no `xl_req`. A miss with nonzero privilege in the same window is walked.
- R4: `xl_req` stays high from the cycle after acceptance until a cycle with `xl_ack` = 1. If `xl_hit` = 0 in that cycle, `done` follows in the next cycle with `done_ok` = 0 and `done_cause` equal to the accepted `miss_cause`. No memory read and no TLB write take place.
- R5: After a translate hit, `mem_req` is high for exactly one cycle with `mem_addr` = the returned `xl_paddr`. The walker then waits any number of cycles for `mem_ack`, and `mem_rdata` is taken in that cycle.
- R6: In the cycle after `mem_ack`, `wr_en` is high for one cycle. In that cycle:
  - `wr_pte` is the read data.
  - `wr_ring` is PTE bits [5:4].
  - `wr_vaddr` is the missing address.
  - `wr_dside` is the side that missed (1 = data).
- R7: Successive refills use ways 1, 2, 3, 0, 1, and so on (the counter is incremented, then used, modulo 4). A failed or suppressed walk does not advance the counter.
- R8: `done` is a one-cycle pulse one cycle after `wr_en`, with `done_ok` = 1. `busy` is high from the cycle after acceptance through the `done` cycle, and low after it.
- R9: `miss_valid` is ignored while `busy` is high. The walk in progress keeps its address and its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A TLB miss is presented |
| miss_vaddr | input | 32 | Missing virtual address |
| miss_dside | input | 1 | 1 = data side missed, 0 = instruction side |
| miss_priv | input | 2 | Privilege level of the missing access |
| miss_cause | input | 6 | Miss cause code to report on failure |
| pt_base | input | 32 | Page-table base register |
| busy | output | 1 | Walk in progress |
| xl_req | output | 1 | Translate request (privilege-0 data load) |
| xl_vaddr | output | 32 | PTE virtual address to translate |
| xl_ack | input | 1 | Translate response valid |
| xl_hit | input | 1 | Translation succeeded |
| xl_paddr | input | 32 | Translated PTE physical address |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Physical PTE address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | PTE read data |
| wr_en | output | 1 | TLB entry write strobe |
| wr_dside | output | 1 | TLB side to write (1 = data) |
| wr_way | output | 2 | Refill way |
| wr_vaddr | output | 32 | Virtual address of the new entry |
| wr_pte | output | 32 | PTE to install |
| wr_ring | output | 2 | Ring of the new entry |
| done | output | 1 | Result pulse |
| done_ok | output | 1 | 1 = refill installed |
| done_cause | output | 6 | Original miss cause |

## Verification
Several behaviours are checked by assertions on every cycle:
- The walker is quiet while idle.
- The memory request is a single cycle.
- A translate request is held until it is acknowledged.
- A suppressed miss goes straight to a failed result.
- Each write is followed by a successful done, and done returns the walker to idle.

The remaining behaviours are shown only by the bench's directed scenarios. These are:
- The PTE address arithmetic.
- The way rotation over many refills, including refills separated by failed walks.
- The data and ring written into the entry.
- Arbitrary acknowledge delays.
- A new miss being ignored while a walk is in progress.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_XLATE,
        S_MEM_REQ,
        S_MEM_WAIT,
        S_WRITE,
        S_DONE
    } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int AW       = 32,
    parameter int PT_SHIFT = 10,
    parameter int WIN_LSB  = 22,
    parameter int ALIGN    = 2
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] pte_vaddr,
    output logic          in_window
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN) - AW'(1));

    always_comb begin
        pte_vaddr = (base | (vaddr >> PT_SHIFT)) & ALIGN_MASK;
        in_window = (vaddr[AW-1:WIN_LSB] == base[AW-1:WIN_LSB]);
    end
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
    parameter int NUM_WAYS = 4,
    localparam int WW = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [WW-1:0] next_way
);
    logic [WW-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   ctr_q <= '0;
        else if (adv) ctr_q <= ctr_q + WW'(1);
    end

    assign next_way = ctr_q + WW'(1);
endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker
    import ptw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CAUSE_W  = 6,
    parameter int NUM_WAYS = 4,
    parameter int PT_SHIFT = 10,
    parameter int WIN_LSB  = 22,
    parameter int RING_LSB = 4,
    localparam int WW = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [AW-1:0]      miss_vaddr,
    input  logic               miss_dside,
    input  logic [1:0]         miss_priv,
    input  logic [CAUSE_W-1:0] miss_cause,
    input  logic [AW-1:0]      pt_base,
    output logic               busy,
    output logic               xl_req,
    output logic [AW-1:0]      xl_vaddr,
    input  logic               xl_ack,
    input  logic               xl_hit,
    input  logic [AW-1:0]      xl_paddr,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               wr_en,
    output logic               wr_dside,
    output logic [WW-1:0]      wr_way,
    output logic [AW-1:0]      wr_vaddr,
    output logic [31:0]        wr_pte,
    output logic [1:0]         wr_ring,
    output logic               done,
    output logic               done_ok,
    output logic [CAUSE_W-1:0] done_cause
);
    walk_state_t state_q, state_d;

    logic [AW-1:0]      va_q, pa_q;
    logic               ds_q, ok_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [31:0]        pte_q;

    logic [AW-1:0] pte_va_live, pte_va_walk;
    logic          win_live, win_walk_unused;
    logic          accept, suppress;

    // window check uses the live request; the PTE address uses the captured one
    ptw_addr_gen #(.AW(AW), .PT_SHIFT(PT_SHIFT), .WIN_LSB(WIN_LSB)) u_gen_live (
        .vaddr(miss_vaddr), .base(pt_base),
        .pte_vaddr(pte_va_live), .in_window(win_live)
    );
    ptw_addr_gen #(.AW(AW), .PT_SHIFT(PT_SHIFT), .WIN_LSB(WIN_LSB)) u_gen_walk (
        .vaddr(va_q), .base(pt_base),
        .pte_vaddr(pte_va_walk), .in_window(win_walk_unused)
    );

    ptw_way_ctr #(.NUM_WAYS(NUM_WAYS)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .adv(state_q == S_WRITE),
        .next_way(wr_way)
    );

    assign accept   = (state_q == S_IDLE) && miss_valid;
    assign suppress = accept && (miss_priv == 2'd0) && win_live;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept) state_d = suppress ? S_DONE : S_XLATE;
            S_XLATE:    if (xl_ack) state_d = xl_hit ? S_MEM_REQ : S_DONE;
            S_MEM_REQ:  state_d = S_MEM_WAIT;
            S_MEM_WAIT: if (mem_ack) state_d = S_WRITE;
            S_WRITE:    state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            pa_q    <= '0;
            ds_q    <= 1'b0;
            ok_q    <= 1'b0;
            cause_q <= '0;
            pte_q   <= '0;
        end else begin
            if (accept) begin
                va_q    <= miss_vaddr;
                ds_q    <= miss_dside;
                cause_q <= miss_cause;
                ok_q    <= 1'b0;
            end
            if (state_q == S_XLATE && xl_ack && xl_hit) pa_q <= xl_paddr;
            if (state_q == S_MEM_WAIT && mem_ack)       pte_q <= mem_rdata;
            if (state_q == S_WRITE)                     ok_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        xl_req     = (state_q == S_XLATE);
        xl_vaddr   = pte_va_walk;
        mem_req    = (state_q == S_MEM_REQ);
        mem_addr   = pa_q;
        wr_en      = (state_q == S_WRITE);
        wr_dside   = ds_q;
        wr_vaddr   = va_q;
        wr_pte     = pte_q;
        wr_ring    = pte_q[RING_LSB +: 2];
        done       = (state_q == S_DONE);
        done_ok    = (state_q == S_DONE) && ok_q;
        done_cause = cause_q;
    end

    // checks next to the logic they guard
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xl_req && !mem_req && !wr_en && !done));

    p_suppress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid && miss_priv == 2'd0 && win_live) |=> (done && !done_ok));

    p_xl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xl_ack) |=> xl_req);

    p_xl_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_ack && !xl_hit) |=> (done && !done_ok));

    p_mem_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_write_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done && done_ok && !wr_en));

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(done_cause));
endmodule

// File: tb/tlb_refill_walker_bench.sv
module tlb_refill_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_vaddr = '0;
    logic        miss_dside = 1'b0;
    logic [1:0]  miss_priv = '0;
    logic [5:0]  miss_cause = '0;
    logic [31:0] pt_base = 32'h8000_0000;
    logic        busy, xl_req, mem_req, wr_en, wr_dside, done, done_ok;
    logic [31:0] xl_vaddr, mem_addr, wr_vaddr, wr_pte;
    logic        xl_ack = 1'b0, xl_hit = 1'b0, mem_ack = 1'b0;
    logic [31:0] xl_paddr = '0, mem_rdata = '0;
    logic [1:0]  wr_way, wr_ring;
    logic [5:0]  done_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tlb_refill_walker u_tlb_refill_walker (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_dside(miss_dside),
        .miss_priv(miss_priv), .miss_cause(miss_cause), .pt_base(pt_base),
        .busy(busy), .xl_req(xl_req), .xl_vaddr(xl_vaddr),
        .xl_ack(xl_ack), .xl_hit(xl_hit), .xl_paddr(xl_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_dside(wr_dside), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
        .wr_pte(wr_pte), .wr_ring(wr_ring),
        .done(done), .done_ok(done_ok), .done_cause(done_cause)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_addr(input logic [31:0] va);
        return (pt_base | (va >> 10)) & 32'hFFFF_FFFC;
    endfunction

    // present one miss for one cycle; the walker sees it on the next edge
    task automatic present(input logic [31:0] va, input logic ds, input logic [1:0] pv,
                           input logic [5:0] cs);
        @(negedge clk);
        miss_valid = 1'b1; miss_vaddr = va; miss_dside = ds; miss_priv = pv; miss_cause = cs;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    // full walk; xh selects the translate outcome
    task automatic run_walk(input logic [31:0] va, input logic ds, input logic [1:0] pv,
                            input logic [5:0] cs, input logic xh, input logic [31:0] pa,
                            input int xdel, input logic [31:0] pte, input int mdel,
                            input logic [1:0] ew);
        logic [31:0] ev;
        ev = pte_addr(va);
        present(va, ds, pv, cs);
        chk(busy, 1, "R8 busy after accept");
        chk(xl_req, 1, "R4 xl_req raised");
        chk(xl_vaddr, ev, "R2 pte address");
        for (int i = 0; i < xdel; i++) begin
            @(negedge clk);
            chk(xl_req, 1, "R4 xl_req held");
        end
        xl_ack = 1'b1; xl_hit = xh; xl_paddr = pa;
        @(negedge clk);
        xl_ack = 1'b0; xl_hit = 1'b0;
        if (!xh) begin
            chk({done, done_ok}, 2'b10, "R4 fail result");
            chk(done_cause, cs, "R4 original cause");
            chk(mem_req | wr_en, 0, "R4 no read or write");
            @(negedge clk);
            chk({busy, done}, 2'b00, "R8 idle after done");
            return;
        end
        chk(mem_req, 1, "R5 mem_req");
        chk(mem_addr, pa, "R5 mem_addr");
        @(negedge clk);
        chk(mem_req, 0, "R5 single pulse");
        for (int i = 0; i < mdel; i++) begin
            @(negedge clk);
            chk(wr_en, 0, "R5 waiting for ack");
        end
        mem_ack = 1'b1; mem_rdata = pte;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(wr_en, 1, "R6 write strobe");
        chk(wr_way, ew, "R7 way");
        chk(wr_pte, pte, "R6 pte");
        chk(wr_ring, pte[5:4], "R6 ring");
        chk(wr_vaddr, va, "R6 vaddr");
        chk(wr_dside, ds, "R6 side");
        @(negedge clk);
        chk({done, done_ok, wr_en}, 3'b110, "R8 done ok");
        chk(busy, 1, "R8 busy through done");
        @(negedge clk);
        chk({busy, done}, 2'b00, "R8 idle after done");
    endtask

    task automatic t_reset();
        chk({busy, xl_req, mem_req, wr_en, done}, 5'b0, "R1 reset outputs");
    endtask

    task automatic t_suppress();
        present(32'h8012_3000, 1'b1, 2'd0, 6'd24);
        chk({done, done_ok}, 2'b10, "R3 suppressed result");
        chk(done_cause, 6'd24, "R3 cause");
        chk(xl_req, 0, "R3 no translate");
        @(negedge clk);
        chk(busy, 0, "R3 idle again");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] ev;
        ev = pte_addr(32'h0040_0000);
        present(32'h0040_0000, 1'b1, 2'd2, 6'd16);
        miss_valid = 1'b1; miss_vaddr = 32'hFFFF_F000; miss_cause = 6'd2;
        @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(xl_vaddr, ev, "R9 address kept");
        xl_ack = 1'b1; xl_hit = 1'b0;
        @(negedge clk);
        xl_ack = 1'b0;
        chk(done_cause, 6'd16, "R9 cause kept");
        @(negedge clk);
        chk(busy, 0, "R9 idle after");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_walk(32'h1234_5678, 1'b1, 2'd1, 6'd24, 1'b1, 32'h0004_8D14, 0, 32'h0ABC_D035, 0, 2'd1);
        run_walk(32'h0000_3000, 1'b0, 2'd3, 6'd16, 1'b1, 32'h0010_0000, 3, 32'h1111_1020, 5, 2'd2);
        run_walk(32'h7FFF_FFFC, 1'b1, 2'd0, 6'd24, 1'b0, 32'h0, 2, 32'h0, 0, 2'd0);
        t_suppress();
        run_walk(32'h8012_3000, 1'b1, 2'd1, 6'd24, 1'b1, 32'h0002_0000, 1, 32'hCAFE_0010, 2, 2'd3);
        run_walk(32'hC000_1000, 1'b0, 2'd0, 6'd16, 1'b1, 32'h0003_0000, 0, 32'h5555_5000, 1, 2'd0);
        t_busy_ignore();
        run_walk(32'h0FFF_0000, 1'b1, 2'd2, 6'd24, 1'b1, 32'h0004_0000, 4, 32'h9999_9030, 7, 2'd1);
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule